// File: doc/BRIEF.md
# Dual-Mode Event Counter with Prescaler Snapshot

This block counts falling edges on asynchronous pulse inputs and keeps a wide snapshot of the count. The counter has a 32-bit count path by default. It can run as one wide counter or as two independent halves, selected by a mode pin. Every count input passes through a synchronizer before its falling edge is detected. All state changes happen on the rising edge of a single system clock.

The snapshot register is 40 bits wide by default. It holds the full counter value above an 8-bit byte taken from an external high-speed prescaler. Bit 7 of that byte is the synchronized primary count input, and the lower seven bits come from a dedicated input. A processor or readout stage reads the snapshot while the counter keeps running.

Top module: `snap_counter`

## Requirements
- R1: Each falling edge on `cnt_a` adds one to the low half (bits `HALF_W-1:0`). The counter changes on the third rising clock edge after the input falls. Rising edges on `cnt_a` and `cnt_b` never change the count.
- R2: With `split` = 0, a step of the low half from all ones to zero adds one to the high half, so both halves form one `2*HALF_W`-bit counter that wraps to zero.
- R3: With `split` = 0, a falling edge on `cnt_b` adds one to the high half only while counter bit `HALF_W` (the least significant bit of the high half) is 0. While that bit is 1, such an edge is ignored.
- R4: With `split` = 1, each falling edge on `cnt_b` adds one to the high half. The low half wraps from all ones to zero without touching the high half.
- R5: While `clr_n` is low, the counter is held at zero. A count edge arriving during the clear is lost, because the clear takes priority.
- R6: While `load_n` is low, `snap` takes a new value on every clock edge. Its bits `SW-1:XW` hold the counter value as updated on that same edge. Bit `XW-1` holds the synchronized `cnt_a`, and bits `XW-2:0` hold `ext_lo`.
- R7: While `load_n` is high, `snap` keeps its value whatever the counter, `ext_lo` or `cnt_a` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear of the counter |
| load_n | input | 1 | Active-low snapshot load; held value while high |
| split | input | 1 | 0: one wide counter, 1: two independent halves |
| cnt_a | input | 1 | Primary count input; also the top bit of the prescaler byte |
| cnt_b | input | 1 | Test count (single mode) or upper-half count (split mode) |
| ext_lo | input | XW-1 | Lower bits of the external prescaler byte |
| snap | output | 2*HALF_W+XW | Snapshot: counter above the prescaler byte |

## Verification
The bench uses 4-bit halves. In that size, a sweep of several hundred `cnt_a` pulses runs the low half through many wraps, and the full 8-bit count wraps as well. This separates a working carry chain (R2) from a missing or doubled carry. The same sweep is run with `cnt_b` pulses mixed in, once in each mode. In single mode the high half's bit 0 then decides whether a test pulse counts (R3). In split mode the high half must advance only on `cnt_b` (R4). Separate short patterns cover the rest:
- a falling edge buried inside a clear (R5),
- a held snapshot while the counter moves (R7),
- a static high `cnt_a`, which must show in the byte without counting (R1, R6).

// File: rtl/snap_counter.sv
module snap_counter #(
  parameter int HALF_W = 16,
  parameter int XW     = 8,
  localparam int W     = 2 * HALF_W,
  localparam int SW    = W + XW
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          split,
  input  logic          cnt_a,
  input  logic          cnt_b,
  input  logic [XW-2:0] ext_lo,
  output logic [SW-1:0] snap
);

  logic [2:0]        sa, sb;
  logic [HALF_W-1:0] lo, hi, lo_nx, hi_nx;
  logic [1:0]        hi_inc;
  logic              fall_a, fall_b, lo_wrap, test_ok;
  logic [W-1:0]      cnt_nx;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[1:0], cnt_a};
      sb <= {sb[1:0], cnt_b};
    end
  end

  assign fall_a  = sa[2] & ~sa[1];
  assign fall_b  = sb[2] & ~sb[1];
  assign lo_wrap = fall_a & (&lo);
  assign test_ok = fall_b & ~hi[0];

  assign hi_inc = split ? {1'b0, fall_b}
                        : {1'b0, test_ok} + {1'b0, lo_wrap};

  assign lo_nx  = lo + {{(HALF_W-1){1'b0}}, fall_a};
  assign hi_nx  = hi + {{(HALF_W-2){1'b0}}, hi_inc};
  assign cnt_nx = clr_n ? {hi_nx, lo_nx} : '0;

  always_ff @(posedge clk) begin
    {hi, lo} <= cnt_nx;
    if (!load_n) snap <= {cnt_nx, sa[1], ext_lo};
  end

endmodule

module snap_counter_chk #(
  parameter int HALF_W = 16,
  parameter int XW     = 8,
  localparam int SW    = 2 * HALF_W + XW
) (
  input logic              clk,
  input logic              clr_n,
  input logic              load_n,
  input logic              split,
  input logic [HALF_W-1:0] lo,
  input logic [HALF_W-1:0] hi,
  input logic [SW-1:0]     snap
);

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!seen)
    !clr_n |=> (hi == '0 && lo == '0));  // R5

  AST_LO_STEP: assert property (@(posedge clk) disable iff (!seen || !clr_n)
    clr_n |=> (lo == $past(lo) || lo == HALF_W'($past(lo) + 1'b1)));  // R1

  AST_TEST_BLOCKED: assert property (@(posedge clk) disable iff (!seen || !clr_n)
    (!split && hi[0] && !(&lo)) |=> hi == $past(hi));  // R3

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!seen)
    !load_n |=> snap[SW-1:XW] == {hi, lo});  // R6

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!seen)
    load_n |=> $stable(snap));  // R7

endmodule

bind snap_counter snap_counter_chk #(.HALF_W(HALF_W), .XW(XW)) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .split(split),
  .lo(lo), .hi(hi), .snap(snap)
);

// File: tb/test_snap_counter.sv
module test_snap_counter;
  localparam int HW = 4;
  localparam int XW = 8;
  localparam int SW = 2 * HW + XW;

  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b0, split = 1'b0, cnt_a = 1'b0, cnt_b = 1'b0;
  logic [XW-2:0] ext_lo = '0;
  logic [SW-1:0] snap;

  int n_chk = 0, n_bad = 0;
  int m_lo = 0, m_hi = 0;

  always #2 clk = ~clk;

  snap_counter #(.HALF_W(HW), .XW(XW)) i_snap_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .split(split),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .ext_lo(ext_lo), .snap(snap)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [SW-1:0] exp);
    n_chk++;
    if (snap !== exp) begin
      n_bad++;
      $display("FAIL %s: snap=%h expected=%h", req, snap, exp);
    end
  endtask

  function automatic logic [SW-1:0] expv(input logic a);
    return {4'(m_hi), 4'(m_lo), a, ext_lo};
  endfunction

  task automatic pulse_a();
    cnt_a = 1'b1; wait_cyc(2);
    cnt_a = 1'b0; wait_cyc(2);
    m_lo = (m_lo + 1) % 16;
    if (!split && m_lo == 0) m_hi = (m_hi + 1) % 16;
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1; wait_cyc(2);
    cnt_b = 1'b0; wait_cyc(2);
    if (split || (m_hi % 2) == 0) m_hi = (m_hi + 1) % 16;
  endtask

  task automatic do_clear();
    clr_n = 1'b0; wait_cyc(4);
    clr_n = 1'b1; wait_cyc(1);
    m_lo = 0; m_hi = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    ext_lo = 7'h2a;
    wait_cyc(5);
    check("R5 reset state", expv(1'b0));
    clr_n = 1'b1; wait_cyc(3);

    // R1 R2: single-mode sweep through several full wraps
    for (int i = 0; i < 300; i++) begin
      ext_lo = 7'(i * 13);
      pulse_a();
      wait_cyc(1);
      check("R1/R2 single sweep", expv(1'b0));
    end

    // R3: test pulses gated by counter bit HALF_W
    do_clear();
    for (int i = 0; i < 120; i++) begin
      if (i % 3 == 0) pulse_b(); else pulse_a();
      wait_cyc(1);
      check("R3 test count gating", expv(1'b0));
    end

    // R3 explicit: high half odd, test pulse ignored
    do_clear();
    pulse_b(); wait_cyc(1);
    check("R3 test pulse counts when bit clear", expv(1'b0));
    pulse_b(); wait_cyc(1);
    check("R3 test pulse ignored when bit set", expv(1'b0));

    // R4: split mode, independent halves
    split = 1'b1;
    do_clear();
    for (int i = 0; i < 150; i++) begin
      if (i % 5 == 0) pulse_b(); else pulse_a();
      wait_cyc(1);
      check("R4 split sweep", expv(1'b0));
    end
    split = 1'b0;

    // R5: falling edge inside clear is lost
    do_clear();
    pulse_a(); pulse_a();
    cnt_a = 1'b1; wait_cyc(3);
    clr_n = 1'b0; wait_cyc(1);
    cnt_a = 1'b0; wait_cyc(4);
    clr_n = 1'b1; wait_cyc(4);
    m_lo = 0; m_hi = 0;
    check("R5 clear beats count edge", expv(1'b0));

    // R1 R6: static high cnt_a shows in byte, no count on rising edge
    pulse_a();
    cnt_a = 1'b1; wait_cyc(4);
    check("R1/R6 rising edge no count, byte msb", expv(1'b1));
    cnt_a = 1'b0; wait_cyc(4);
    m_lo = (m_lo + 1) % 16;
    check("R1 falling edge counts", expv(1'b0));

    // R7: hold while load_n high
    begin
      logic [SW-1:0] held;
      held = snap;
      load_n = 1'b1; wait_cyc(1);
      pulse_a(); pulse_a(); pulse_b();
      ext_lo = 7'h55; cnt_a = 1'b1; wait_cyc(3);
      check("R7 snapshot held", held);
      cnt_a = 1'b0; wait_cyc(4);
      m_lo = (m_lo + 1) % 16;
      check("R7 snapshot still held", held);
      load_n = 1'b0; wait_cyc(1);
      check("R6 reload after hold", expv(1'b0));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule